// File: doc/BRIEF.md
# UART Register and Command Controller

This block is the register front end of a serial port. A byte-wide bus with 6-bit addresses reaches two mode bytes, a status byte, an interrupt status byte, an interrupt mask and two read-only baud-divider bytes. A packed command byte can reset parts of the port and can turn the transmitter and the receiver on or off. One byte written for transmission waits in a single holding register. It leaves on a valid/ready handshake. A single level interrupt is raised from the interrupt status, gated by the mask.

The two mode bytes share one address and are selected by a one-bit pointer. Every mode write leaves the pointer on the second byte, and one sub-command moves it back to the first. Receive storage, serial bit timing and baud generation belong to neighbouring blocks. This block sees receive storage only through its ready, full, error and data inputs, and it sends pop and flush pulses back to it.

Top module: `uart_ctl_regs`

## Requirements
- R1: After reset both mode bytes, the mask and the mode pointer are zero. Transmitter and receiver are disabled, `tx_valid` and `irq` are low, and status reads 0x08 while the receive inputs are low.
- R2: A write to 0x00 stores into the first mode byte when the pointer is 0 and into the second when it is 1, then sets the pointer to 1. A read of 0x00 returns the byte the pointer selects. Command field [6:4]=1 clears the pointer.
- R3: Command field [6:4]=2 disables the receiver and pulses `rx_flush` in the write cycle. Value 3 disables the transmitter and marks the holding register empty, dropping any pending byte. Value 5 clears the break-change flag. Values 0, 4, 6 and 7 change nothing.
- R4: Command field [3:2] enables the transmitter with 1 and disables it with 2. Field [1:0] does the same for the receiver. The value 3 in either field is ignored. Both fields act after field [6:4] of the same byte, so they win over it.
- R5: Status bits, LSB first: receive data ready, receive full, transmitter enabled, holding register empty, then `rx_err[3:0]` in bits 7:4.
- R6: A write to 0x0C loads the holding register and clears the empty bit. `tx_valid` is high only while the transmitter is enabled and the register is not empty. `tx_data` stays stable while the byte waits. The empty bit returns in the cycle after `tx_valid` and `tx_ready` are both high.
- R7: Interrupt status at 0x14 reads bit0 = transmitter enabled and bit2 = break-change flag. Bit1 = receive full when bit 6 of the first mode byte is set, and receive ready when it is clear. All other bits are 0.
- R8: A write to 0x14 sets the mask. `irq` is high exactly when interrupt status AND mask is nonzero.
- R9: Writes to 0x04, 0x10 and all unmapped addresses change nothing. Reads of 0x08, 0x10 and unmapped addresses return 0.
- R10: A read of 0x0C returns `rx_data` and pulses `rx_pop` when `rx_ready` is high. Otherwise it returns 0 with no pop.
- R11: Reads of 0x18 and 0x1C return the parameters `BAUD_DIV_HI` and `BAUD_DIV_LO`.
- R12: A `brk_evt` pulse sets the break-change flag. If it coincides with command value 5, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on the address |
| tx_valid | output | 1 | Held byte offered to the transmitter |
| tx_data | output | 8 | Held byte |
| tx_ready | input | 1 | Transmitter accepts the byte |
| rx_ready | input | 1 | Receive storage holds data |
| rx_full | input | 1 | Receive storage is full |
| rx_err | input | 4 | Overrun, parity, framing and break flags from receive storage |
| rx_data | input | 8 | Oldest receive byte |
| brk_evt | input | 1 | Break-change event pulse |
| rx_en | output | 1 | Receiver enable |
| rx_pop | output | 1 | Remove the oldest receive byte |
| rx_flush | output | 1 | Discard all receive bytes |
| irq | output | 1 | Level interrupt |

## Verification
The bench sets the divider parameters to 0x12 and 0x34 instead of their defaults. A readback at 0x18 and 0x1C then proves that the values reach the bus and are not hard-wired. The receive-interrupt select bit stays at its default position 6, so the bench can flip the receive interrupt source by rewriting the first mode byte with 0x40. The same setting lets the bench test the pointer wrap and the ordering of the three command fields within one byte.

// File: rtl/uart_ctl_pkg.sv
package uart_ctl_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 6;
    localparam int ERR_W  = DATA_W - 4;

    localparam logic [ADDR_W-1:0] A_MODE = 6'h00;
    localparam logic [ADDR_W-1:0] A_STAT = 6'h04;
    localparam logic [ADDR_W-1:0] A_CMD  = 6'h08;
    localparam logic [ADDR_W-1:0] A_DATA = 6'h0C;
    localparam logic [ADDR_W-1:0] A_ISR  = 6'h14;
    localparam logic [ADDR_W-1:0] A_DIV1 = 6'h18;
    localparam logic [ADDR_W-1:0] A_DIV2 = 6'h1C;

    // Misc sub-command in command bits [6:4]
    typedef enum logic [2:0] {
        MISC_NOP     = 3'd0,
        MISC_PTR_CLR = 3'd1,
        MISC_RX_RST  = 3'd2,
        MISC_TX_RST  = 3'd3,
        MISC_ERR_CLR = 3'd4,
        MISC_BRK_ACK = 3'd5,
        MISC_BRK_ON  = 3'd6,
        MISC_BRK_OFF = 3'd7
    } misc_e;

    // Decoded command actions, each already qualified by the write strobe
    typedef struct packed {
        logic ptr_clr;
        logic rx_rst;
        logic tx_rst;
        logic brk_ack;
        logic tx_on;
        logic tx_off;
        logic rx_on;
        logic rx_off;
    } cmd_t;

    typedef struct packed {
        logic [DATA_W-1:0] mode1;
        logic [DATA_W-1:0] mode2;
        logic              ptr;
        logic [DATA_W-1:0] imr;
        logic              tx_en;
        logic              rx_en;
        logic              brk;
    } regs_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              empty;
    } hold_t;

endpackage

// File: rtl/uart_cmd_decode.sv
module uart_cmd_decode
    import uart_ctl_pkg::*;
(
    input  logic              strobe,
    input  logic [DATA_W-1:0] cmd_byte,
    output cmd_t              cmd
);

    misc_e      misc;
    logic [1:0] tx_fld;
    logic [1:0] rx_fld;

    always_comb begin
        misc   = misc_e'(cmd_byte[6:4]);
        tx_fld = cmd_byte[3:2];
        rx_fld = cmd_byte[1:0];
        cmd    = '0;
        if (strobe) begin
            case (misc)
                MISC_PTR_CLR: cmd.ptr_clr = 1'b1;
                MISC_RX_RST:  cmd.rx_rst  = 1'b1;
                MISC_TX_RST:  cmd.tx_rst  = 1'b1;
                MISC_BRK_ACK: cmd.brk_ack = 1'b1;
                default:      ;
            endcase
            // value 3 in either field is reserved: no action
            cmd.tx_on  = (tx_fld == 2'd1);
            cmd.tx_off = (tx_fld == 2'd2);
            cmd.rx_on  = (rx_fld == 2'd1);
            cmd.rx_off = (rx_fld == 2'd2);
        end
    end

endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
    import uart_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              drop,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic              empty
);

    hold_t hold_d, hold_q;

    assign tx_valid = tx_en && !hold_q.empty;
    assign tx_data  = hold_q.data;
    assign empty    = hold_q.empty;

    always_comb begin
        hold_d = hold_q;
        if (tx_valid && tx_ready) hold_d.empty = 1'b1;
        if (drop)                 hold_d.empty = 1'b1;
        // a new byte overrides a completing handshake on the old one
        if (load) begin
            hold_d.data  = load_data;
            hold_d.empty = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q.data  <= '0;
            hold_q.empty <= 1'b1;
        end else begin
            hold_q <= hold_d;
        end
    end

endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen
    import uart_ctl_pkg::*;
(
    input  logic              tx_en,
    input  logic              rx_ready,
    input  logic              rx_full,
    input  logic              sel_full,
    input  logic              brk,
    input  logic [DATA_W-1:0] imr,
    output logic [DATA_W-1:0] isr,
    output logic              irq
);

    always_comb begin
        isr    = '0;
        isr[0] = tx_en;
        isr[1] = sel_full ? rx_full : rx_ready;
        isr[2] = brk;
        irq    = |(isr & imr);
    end

endmodule

// File: rtl/uart_ctl_regs.sv
module uart_ctl_regs
    import uart_ctl_pkg::*;
#(
    parameter logic [DATA_W-1:0] BAUD_DIV_HI = 8'h00,
    parameter logic [DATA_W-1:0] BAUD_DIV_LO = 8'h1A,
    parameter int                RX_SEL_BIT  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_ready,
    input  logic              rx_ready,
    input  logic              rx_full,
    input  logic [ERR_W-1:0]  rx_err,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              brk_evt,
    output logic              rx_en,
    output logic              rx_pop,
    output logic              rx_flush,
    output logic              irq
);

    regs_t             q, d;
    cmd_t              cmd;
    logic              wr_mode, wr_cmd, wr_data, wr_mask, rd_data;
    logic              tx_empty;
    logic [DATA_W-1:0] status;
    logic [DATA_W-1:0] isr;

    assign wr_mode = bus_wr && (bus_addr == A_MODE);
    assign wr_cmd  = bus_wr && (bus_addr == A_CMD);
    assign wr_data = bus_wr && (bus_addr == A_DATA);
    assign wr_mask = bus_wr && (bus_addr == A_ISR);
    assign rd_data = bus_rd && (bus_addr == A_DATA);

    uart_cmd_decode u_dec (
        .strobe   (wr_cmd),
        .cmd_byte (bus_wdata),
        .cmd      (cmd)
    );

    uart_tx_hold u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (q.tx_en),
        .load      (wr_data),
        .load_data (bus_wdata),
        .drop      (cmd.tx_rst),
        .tx_ready  (tx_ready),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .empty     (tx_empty)
    );

    uart_irq_gen u_irq (
        .tx_en    (q.tx_en),
        .rx_ready (rx_ready),
        .rx_full  (rx_full),
        .sel_full (q.mode1[RX_SEL_BIT]),
        .brk      (q.brk),
        .imr      (q.imr),
        .isr      (isr),
        .irq      (irq)
    );

    assign status   = {rx_err, tx_empty, q.tx_en, rx_full, rx_ready};
    assign rx_en    = q.rx_en;
    assign rx_pop   = rd_data && rx_ready;
    assign rx_flush = cmd.rx_rst;

    // next-state computation
    always_comb begin
        d = q;
        if (wr_mode) begin
            if (q.ptr) d.mode2 = bus_wdata;
            else       d.mode1 = bus_wdata;
            d.ptr = 1'b1;
        end
        // misc field first, then enable fields override it
        if (cmd.ptr_clr) d.ptr   = 1'b0;
        if (cmd.rx_rst)  d.rx_en = 1'b0;
        if (cmd.tx_rst)  d.tx_en = 1'b0;
        if (cmd.brk_ack) d.brk   = 1'b0;
        if (cmd.tx_on)   d.tx_en = 1'b1;
        if (cmd.tx_off)  d.tx_en = 1'b0;
        if (cmd.rx_on)   d.rx_en = 1'b1;
        if (cmd.rx_off)  d.rx_en = 1'b0;
        if (brk_evt)     d.brk   = 1'b1;
        if (wr_mask)     d.imr   = bus_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // read mux
    always_comb begin
        case (bus_addr)
            A_MODE:  bus_rdata = q.ptr ? q.mode2 : q.mode1;
            A_STAT:  bus_rdata = status;
            A_DATA:  bus_rdata = rx_ready ? rx_data : '0;
            A_ISR:   bus_rdata = isr;
            A_DIV1:  bus_rdata = BAUD_DIV_HI;
            A_DIV2:  bus_rdata = BAUD_DIV_LO;
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/uart_ctl_chk.sv
module uart_ctl_chk
    import uart_ctl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [DATA_W-1:0] tx_data,
    input logic              tx_en,
    input logic              ptr,
    input logic              brk,
    input logic [DATA_W-1:0] imr,
    input logic              irq,
    input logic              rx_pop,
    input logic              rx_ready,
    input logic              rx_flush,
    input logic              rx_en,
    input logic              brk_evt
);

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready && !bus_wr |=> tx_valid && $stable(tx_data)); // R6

    AST_TX_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready && !bus_wr |=> !tx_valid); // R6

    AST_TX_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> !tx_valid); // R6

    AST_PTR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && (bus_addr == A_MODE) |=> ptr); // R2

    AST_POP_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> rx_ready); // R10

    AST_FLUSH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush && (bus_wdata[1:0] != 2'b01) |=> !rx_en); // R3

    AST_BRK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        brk_evt |=> brk); // R12

    AST_IRQ_TX: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en && imr[0] |-> irq); // R8

endmodule

bind uart_ctl_regs uart_ctl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .tx_en     (q.tx_en),
    .ptr       (q.ptr),
    .brk       (q.brk),
    .imr       (q.imr),
    .irq       (irq),
    .rx_pop    (rx_pop),
    .rx_ready  (rx_ready),
    .rx_flush  (rx_flush),
    .rx_en     (rx_en),
    .brk_evt   (brk_evt)
);

// File: tb/tb_uart_ctl_regs.sv
`timescale 1ns/1ps
module tb_uart_ctl_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       tx_ready = 1'b0;
    logic       rx_ready = 1'b0, rx_full = 1'b0;
    logic [3:0] rx_err = '0;
    logic [7:0] rx_data = '0;
    logic       brk_evt = 1'b0;
    logic       rx_en, rx_pop, rx_flush, irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] got;
    logic       last_pop, last_flush;

    always #2 clk = ~clk;

    uart_ctl_regs #(.BAUD_DIV_HI(8'h12), .BAUD_DIV_LO(8'h34)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_ready(rx_ready), .rx_full(rx_full), .rx_err(rx_err),
        .rx_data(rx_data), .brk_evt(brk_evt), .rx_en(rx_en),
        .rx_pop(rx_pop), .rx_flush(rx_flush), .irq(irq)
    );

    typedef struct packed {
        logic       is_wr;
        logic [5:0] a;
        logic [7:0] v;   // write data, or expected read data
        logic [3:0] req;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b0, 6'h00, 8'h00, 4'd1},  // R1 mode byte zero
        '{1'b0, 6'h04, 8'h08, 4'd1},  // R1 only empty set
        '{1'b0, 6'h14, 8'h00, 4'd1},  // R1 no interrupt status
        '{1'b1, 6'h00, 8'hA5, 4'd2},  // R2 first mode byte
        '{1'b1, 6'h00, 8'h3C, 4'd2},  // R2 second mode byte
        '{1'b0, 6'h00, 8'h3C, 4'd2},  // R2 pointer on second
        '{1'b1, 6'h08, 8'h10, 4'd2},  // R2 pointer clear
        '{1'b0, 6'h00, 8'hA5, 4'd2},  // R2 first byte back
        '{1'b1, 6'h08, 8'h04, 4'd4},  // R4 tx enable
        '{1'b0, 6'h04, 8'h0C, 4'd5},  // R5 ready + empty
        '{1'b0, 6'h14, 8'h01, 4'd7},  // R7 tx interrupt bit
        '{1'b1, 6'h0C, 8'h5A, 4'd6},  // R6 load byte
        '{1'b0, 6'h04, 8'h04, 4'd6},  // R6 empty cleared
        '{1'b1, 6'h08, 8'h08, 4'd4},  // R4 tx disable
        '{1'b0, 6'h04, 8'h00, 4'd4},  // R4 ready gone
        '{1'b1, 6'h08, 8'h30, 4'd3},  // R3 transmitter reset
        '{1'b0, 6'h04, 8'h08, 4'd3},  // R3 empty restored
        '{1'b1, 6'h08, 8'h34, 4'd4},  // R4 reset then enable
        '{1'b0, 6'h04, 8'h0C, 4'd4},  // R4 enable wins
        '{1'b1, 6'h08, 8'h0C, 4'd4},  // R4 reserved tx field
        '{1'b0, 6'h04, 8'h0C, 4'd4},  // R4 unchanged
        '{1'b1, 6'h08, 8'h40, 4'd3},  // R3 misc value 4
        '{1'b0, 6'h00, 8'hA5, 4'd3},  // R3 pointer untouched
        '{1'b1, 6'h04, 8'hFF, 4'd9},  // R9 clock-select write
        '{1'b1, 6'h10, 8'hFF, 4'd9},  // R9 ignored write
        '{1'b1, 6'h3C, 8'h77, 4'd9},  // R9 unmapped write
        '{1'b0, 6'h3C, 8'h00, 4'd9},  // R9 unmapped read
        '{1'b0, 6'h10, 8'h00, 4'd9},  // R9 reads zero
        '{1'b0, 6'h04, 8'h0C, 4'd9},  // R9 status intact
        '{1'b0, 6'h18, 8'h12, 4'd11}, // R11 divider high
        '{1'b0, 6'h1C, 8'h34, 4'd11}, // R11 divider low
        '{1'b0, 6'h08, 8'h00, 4'd9}   // R9 command reads zero
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        #1 last_flush = rx_flush;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 got = bus_rdata; last_pop = rx_pop;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 irq", {7'b0, irq}, 8'h00);
        chk("R1 tx_valid", {7'b0, tx_valid}, 8'h00);
        chk("R1 rx_en", {7'b0, rx_en}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].is_wr) wr(VECS[i].a, VECS[i].v);
            else begin
                rd(VECS[i].a);
                chk($sformatf("R%0d vec%0d", VECS[i].req, i), got, VECS[i].v);
            end
        end

        // R6 handshake
        wr(6'h0C, 8'hC3);
        #1;
        chk("R6 valid", {7'b0, tx_valid}, 8'h01);
        chk("R6 data", tx_data, 8'hC3);
        repeat (3) @(negedge clk);
        #1;
        chk("R6 held", {7'b0, tx_valid}, 8'h01);
        rd(6'h04);
        chk("R6 status pending", got, 8'h04);
        @(negedge clk); tx_ready = 1'b1;
        @(negedge clk); tx_ready = 1'b0;
        #1;
        chk("R6 valid after", {7'b0, tx_valid}, 8'h00);
        rd(6'h04);
        chk("R6 empty back", got, 8'h0C);

        // R7 / R8 receive interrupt select
        wr(6'h14, 8'h02);
        rx_ready = 1'b1;
        rd(6'h14);
        chk("R7 ready source", got, 8'h03);
        chk("R8 irq on", {7'b0, irq}, 8'h01);
        wr(6'h08, 8'h10);
        wr(6'h00, 8'h40);
        rd(6'h14);
        chk("R7 full source", got, 8'h01);
        chk("R8 irq off", {7'b0, irq}, 8'h00);
        rx_full = 1'b1;
        rd(6'h14);
        chk("R7 full set", got, 8'h03);
        chk("R8 irq full", {7'b0, irq}, 8'h01);
        wr(6'h14, 8'h00);
        #1 chk("R8 masked", {7'b0, irq}, 8'h00);
        wr(6'h14, 8'h01);
        #1 chk("R8 tx mask", {7'b0, irq}, 8'h01);
        wr(6'h14, 8'h00);
        rx_full = 1'b0;

        // R10 receive data
        rx_data = 8'h9E;
        rd(6'h0C);
        chk("R10 data", got, 8'h9E);
        chk("R10 pop", {7'b0, last_pop}, 8'h01);
        rx_ready = 1'b0;
        rd(6'h0C);
        chk("R10 empty data", got, 8'h00);
        chk("R10 no pop", {7'b0, last_pop}, 8'h00);

        // R3 / R4 receiver commands
        wr(6'h08, 8'h01);
        chk("R4 rx on", {7'b0, rx_en}, 8'h01);
        wr(6'h08, 8'h20);
        chk("R3 flush", {7'b0, last_flush}, 8'h01);
        chk("R3 rx off", {7'b0, rx_en}, 8'h00);
        wr(6'h08, 8'h21);
        chk("R4 flush then on", {7'b0, rx_en}, 8'h01);
        wr(6'h08, 8'h03);
        chk("R4 reserved rx", {7'b0, rx_en}, 8'h01);
        wr(6'h08, 8'h02);
        chk("R4 rx disable", {7'b0, rx_en}, 8'h00);

        // R12 break flag
        @(negedge clk); brk_evt = 1'b1;
        @(negedge clk); brk_evt = 1'b0;
        rd(6'h14);
        chk("R12 break set", got, 8'h05);
        wr(6'h08, 8'h50);
        rd(6'h14);
        chk("R3 break ack", got, 8'h01);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 6'h08; bus_wdata = 8'h50; brk_evt = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; brk_evt = 1'b0;
        rd(6'h14);
        chk("R12 set wins", got, 8'h05);
        wr(6'h14, 8'h04);
        #1 chk("R8 break irq", {7'b0, irq}, 8'h01);
        wr(6'h08, 8'h50);
        #1 chk("R8 break cleared", {7'b0, irq}, 8'h00);

        // R5 error bits
        rx_err = 4'hA;
        rd(6'h04);
        chk("R5 error bits", got, 8'hAC);
        rx_err = 4'h0;

        // R1 reset mid-run
        wr(6'h08, 8'h01);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd(6'h00);
        chk("R1 mode after reset", got, 8'h00);
        rd(6'h04);
        chk("R1 status after reset", got, 8'h08);
        rd(6'h14);
        chk("R1 isr after reset", got, 8'h00);
        chk("R1 rx_en after reset", {7'b0, rx_en}, 8'h00);
        chk("R1 irq after reset", {7'b0, irq}, 8'h00);

        finish_run();
    end

endmodule